// File: doc/BRIEF.md
# Oversampling Touch-ADC Scan Sequencer

This block is an SPI master that runs one scan of a resistive-touch converter each time it receives a start pulse. It walks an eight-bit channel enable mask from the lowest index upward. For every enabled channel it sends a burst of 24-bit frames. Each frame carries one command byte and then reads back a 16-bit word. The first frames of a burst give the analog front end time to settle, so their results are dropped. The remaining frames are summed, and the sum is divided by their count, rounding up. That average is the channel's 12-bit result.

Results fill a bank of result slots in scan order, and a one-cycle done pulse marks the end of the scan. The settling count and the oversampling count can be set separately for each channel. The converter stays powered through a burst and is allowed to power itself down on the last frame. The chip select stays low across the whole scan.

Top module: `touch_adc_scanner`

## Requirements
- R1: Every command byte is laid out as follows. Bit 7 is 1. Bits 6:4 hold the channel index. Bit 3 is 0, which selects 12-bit conversion. Bit 2 equals the SINGLE_ENDED parameter. Bits 1:0 are the power field.
- R2: A frame is 24 SCLK pulses in SPI mode 0. SCLK idles low. MOSI changes only while SCLK is low and is sent MSB first. MOSI is 0 during the final 16 pulses. MISO is sampled on rising SCLK edges.
- R3: The value of a frame is bits 14:3 of the 16-bit word read during its last 16 pulses. Bit 15 and bits 2:0 of that word have no effect on any result.
- R4: Enabled channels are visited in ascending index order. The k-th enabled channel's result goes to slot k, starting from slot 0. Slots beyond the number of enabled channels keep their earlier contents.
- R5: A channel's burst holds S + E frames, where S is its settling count and E is its effective oversampling count. Only the frames after the first S contribute to the result.
- R6: The power field is 01 on every frame of a burst except the last one, which sends 00.
- R7: A result equals ceil(sum of kept values / E). This holds with no overflow for up to fifteen kept values of 4095 each.
- R8: Settling and oversampling counts each range from 0 to 15. An oversampling count of 0 is treated as 1, and a settling count of 0 keeps every frame.
- R9: CS_n goes low on the clock edge that accepts a start and stays low until the scan ends. It goes back high in the same cycle that done is raised.
- R10: SCLK stays high for exactly HALF_DIV clock cycles on every pulse. Each low phase inside a frame also lasts HALF_DIV cycles.
- R11: A start pulse that arrives while a scan is running is ignored. It produces no second scan and no extra done pulse.
- R12: With an all-zero mask, done is high in the cycle right after the start is sampled. There is no SPI activity in that case.
- R13: Done is a single-cycle pulse. After reset, CS_n is 1, SCLK is 0, MOSI is 0, done is 0 and every result slot is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begins a scan when the block is idle |
| ch_en | input | NUM_CH | Channel enable mask, bit i enables channel i |
| settle_cnt | input | NUM_CH*CNT_W | Per-channel count of discarded frames, channel i in field i |
| ovs_cnt | input | NUM_CH*CNT_W | Per-channel count of averaged frames, channel i in field i |
| miso | input | 1 | Serial data from the converter |
| sclk | output | 1 | SPI clock, mode 0 |
| mosi | output | 1 | Serial command data to the converter |
| cs_n | output | 1 | Active-low chip select, held low for the scan |
| result | output | NUM_CH*SAMPLE_W | Result bank, slot k in field k |
| done | output | 1 | One-cycle pulse at the end of a scan |

## Verification
The case hardest to reach from the ports is a start pulse that lands in the middle of a running burst. It has to come after the first frame has begun and before the divider has returned. The stimulus raises start a fixed number of cycles after the scan is accepted, while the scan is known to be in its first frame. The bench then checks that exactly one done pulse occurs and that CS_n stays high for a while afterwards. The model of the converter reports values that depend on channel and frame index, and it sets bit 15 and bits 2:0 of every reply to 1. A result that picked up a settling frame, a frame from a neighbouring channel, or a junk bit would therefore differ from the arithmetic expectation.

// File: rtl/tscan_pkg.sv
// Shared constants and helpers for the touch-ADC scan sequencer.
// Assumes an 8-bit command followed by a 16-bit read phase per frame.
package tscan_pkg;

    localparam int FRAME_BITS = 24;
    localparam int RX_BITS    = 16;
    localparam int DATA_MSB   = 14;   // result field top bit in the read word
    localparam int DATA_LSB   = 3;    // result field bottom bit in the read word

    localparam logic [1:0] PWR_STAY_ON  = 2'b01;
    localparam logic [1:0] PWR_AUTO_OFF = 2'b00;

    typedef enum logic [1:0] {
        SQ_IDLE,
        SQ_LAUNCH,
        SQ_WAIT,
        SQ_DIVIDE
    } seq_state_e;

    // Assemble one command byte: start bit, address, 12-bit mode, reference select, power field.
    function automatic logic [7:0] make_cmd(input logic [2:0] addr,
                                            input logic       single_ended,
                                            input logic       stay_on);
        return {1'b1, addr, 1'b0, single_ended, (stay_on ? PWR_STAY_ON : PWR_AUTO_OFF)};
    endfunction

endpackage

// File: rtl/tscan_spi_frame.sv
// SPI mode-0 frame engine: sends one command byte, then clocks in a 16-bit word
// while driving MOSI low. SCLK half-period is HALF_DIV system cycles.
// Assumes go is only pulsed while the engine is idle.
module tscan_spi_frame
    import tscan_pkg::*;
#(
    parameter int HALF_DIV = 34,
    parameter int SAMPLE_W = 12
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                go,
    input  logic [7:0]          cmd,
    input  logic                miso,
    output logic                sclk,
    output logic                mosi,
    output logic                word_vld,
    output logic [SAMPLE_W-1:0] word_data
);

    localparam int DIV_W = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
    localparam int BIT_W = $clog2(FRAME_BITS);

    logic                  active_q;
    logic [DIV_W-1:0]      div_q;
    logic [BIT_W-1:0]      bit_q;
    logic [FRAME_BITS-1:0] tx_q;
    logic [RX_BITS-1:0]    rx_q;
    logic                  sclk_q;
    logic                  vld_q;
    logic                  tick;

    assign tick      = (div_q == DIV_W'(HALF_DIV - 1));
    assign sclk      = sclk_q;
    assign mosi      = tx_q[FRAME_BITS-1];
    assign word_vld  = vld_q;
    assign word_data = rx_q[DATA_MSB:DATA_LSB];

    // Frame timing: load, toggle SCLK on each divider tick, shift on edges.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q <= 1'b0;
            div_q    <= '0;
            bit_q    <= '0;
            tx_q     <= '0;
            rx_q     <= '0;
            sclk_q   <= 1'b0;
            vld_q    <= 1'b0;
        end else begin
            vld_q <= 1'b0;
            if (!active_q) begin
                if (go) begin
                    active_q <= 1'b1;
                    tx_q     <= {cmd, {RX_BITS{1'b0}}};
                    div_q    <= '0;
                    bit_q    <= '0;
                    sclk_q   <= 1'b0;
                end
            end else if (tick) begin
                div_q <= '0;
                if (!sclk_q) begin
                    sclk_q <= 1'b1;
                    rx_q   <= {rx_q[RX_BITS-2:0], miso};
                end else begin
                    sclk_q <= 1'b0;
                    tx_q   <= {tx_q[FRAME_BITS-2:0], 1'b0};
                    if (bit_q == BIT_W'(FRAME_BITS - 1)) begin
                        active_q <= 1'b0;
                        vld_q    <= 1'b1;
                    end else begin
                        bit_q <= bit_q + 1'b1;
                    end
                end
            end else begin
                div_q <= div_q + 1'b1;
            end
        end
    end

endmodule

// File: rtl/tscan_averager.sv
// Accumulates kept samples and performs a serial restoring division of
// (sum + divisor - 1) by divisor, giving a rounded-up average after ACC_W cycles.
// Assumes divisor is non-zero and stable while a division runs.
module tscan_averager #(
    parameter int SAMPLE_W = 12,
    parameter int CNT_W    = 4,
    parameter int ACC_W    = 20
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                acc_clear,
    input  logic                acc_add,
    input  logic [SAMPLE_W-1:0] sample,
    input  logic                div_go,
    input  logic [CNT_W-1:0]    divisor,
    output logic                div_done,
    output logic [SAMPLE_W-1:0] quotient
);

    localparam int STEP_W = $clog2(ACC_W + 1);

    logic [ACC_W-1:0]  acc_q;
    logic [ACC_W-1:0]  num_q;
    logic [CNT_W-1:0]  rem_q;
    logic [STEP_W-1:0] steps_q;
    logic              run_q;
    logic              done_q;
    logic [CNT_W:0]    rem_shift;
    logic [CNT_W:0]    rem_diff;
    logic              fits;

    // One restoring-division step on the current remainder.
    always_comb begin
        rem_shift = {rem_q, num_q[ACC_W-1]};
        fits      = (rem_shift >= {1'b0, divisor});
        rem_diff  = rem_shift - {1'b0, divisor};
    end

    assign div_done = done_q;
    assign quotient = num_q[SAMPLE_W-1:0];

    // Running sum of kept samples for the current burst.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q <= '0;
        end else if (acc_clear) begin
            acc_q <= '0;
        end else if (acc_add) begin
            acc_q <= acc_q + ACC_W'(sample);
        end
    end

    // Serial divider: numerator shifts out, quotient bits shift in.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            num_q   <= '0;
            rem_q   <= '0;
            steps_q <= '0;
            run_q   <= 1'b0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (div_go) begin
                num_q   <= acc_q + ACC_W'(divisor) - ACC_W'(1);
                rem_q   <= '0;
                steps_q <= STEP_W'(ACC_W);
                run_q   <= 1'b1;
            end else if (run_q) begin
                num_q   <= {num_q[ACC_W-2:0], fits};
                rem_q   <= fits ? CNT_W'(rem_diff) : CNT_W'(rem_shift);
                steps_q <= steps_q - 1'b1;
                if (steps_q == STEP_W'(1)) begin
                    run_q  <= 1'b0;
                    done_q <= 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/tscan_sequencer.sv
// Scan controller: latches the mask and counts on start, walks enabled channels
// upward, issues each burst frame by frame, gates accumulation past the settling
// frames, starts the division and hands the result to the bank.
// Assumes NUM_CH <= 8 so the channel index fits the 3-bit address field.
module tscan_sequencer
    import tscan_pkg::*;
#(
    parameter int  NUM_CH       = 8,
    parameter int  CNT_W        = 4,
    parameter int  SAMPLE_W     = 12,
    parameter bit  SINGLE_ENDED = 1'b0
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      start,
    input  logic [NUM_CH-1:0]         ch_en,
    input  logic [NUM_CH*CNT_W-1:0]   settle_cnt,
    input  logic [NUM_CH*CNT_W-1:0]   ovs_cnt,
    input  logic                      frame_vld,
    output logic                      frame_go,
    output logic [7:0]                frame_cmd,
    output logic                      acc_clear,
    output logic                      acc_add,
    output logic                      div_go,
    output logic [CNT_W-1:0]          divisor,
    input  logic                      div_done,
    input  logic [SAMPLE_W-1:0]       div_quo,
    output logic                      wr_en,
    output logic [$clog2(NUM_CH)-1:0] wr_slot,
    output logic [SAMPLE_W-1:0]       wr_data,
    output logic                      cs_n,
    output logic                      done
);

    localparam int CH_W = $clog2(NUM_CH);
    localparam int FI_W = CNT_W + 1;

    seq_state_e                state_q;
    logic [NUM_CH-1:0]         mask_q;
    logic [NUM_CH*CNT_W-1:0]   settle_q;
    logic [NUM_CH*CNT_W-1:0]   ovs_q;
    logic [CH_W-1:0]           ch_q;
    logic [CH_W-1:0]           slot_q;
    logic [FI_W-1:0]           frame_q;
    logic                      cs_n_q;
    logic                      done_q;
    logic                      go_q;
    logic                      clear_q;
    logic                      div_go_q;

    logic [CNT_W-1:0]          cur_settle;
    logic [CNT_W-1:0]          cur_ovs;
    logic [FI_W-1:0]           last_frame;
    logic                      is_last;
    logic                      first_found;
    logic [CH_W-1:0]           first_idx;
    logic                      next_found;
    logic [CH_W-1:0]           next_idx;

    // Per-channel counts of the channel being scanned; zero oversampling means one.
    always_comb begin
        cur_settle = settle_q[ch_q*CNT_W +: CNT_W];
        cur_ovs    = ovs_q[ch_q*CNT_W +: CNT_W];
        if (cur_ovs == '0) begin
            cur_ovs = CNT_W'(1);
        end
        last_frame = FI_W'(cur_settle) + FI_W'(cur_ovs) - FI_W'(1);
        is_last    = (frame_q == last_frame);
    end

    // Lowest enabled channel in the incoming mask.
    always_comb begin
        first_found = 1'b0;
        first_idx   = '0;
        for (int i = NUM_CH - 1; i >= 0; i--) begin
            if (ch_en[i]) begin
                first_found = 1'b1;
                first_idx   = CH_W'(i);
            end
        end
    end

    // Lowest enabled channel above the current one in the latched mask.
    always_comb begin
        next_found = 1'b0;
        next_idx   = '0;
        for (int i = NUM_CH - 1; i >= 0; i--) begin
            if (mask_q[i] && (CH_W'(i) > ch_q)) begin
                next_found = 1'b1;
                next_idx   = CH_W'(i);
            end
        end
    end

    assign frame_cmd = make_cmd(3'(ch_q), SINGLE_ENDED, !is_last);
    assign frame_go  = go_q;
    assign acc_clear = clear_q;
    assign acc_add   = (state_q == SQ_WAIT) && frame_vld && (frame_q >= FI_W'(cur_settle));
    assign div_go    = div_go_q;
    assign divisor   = cur_ovs;
    assign wr_en     = (state_q == SQ_DIVIDE) && div_done;
    assign wr_slot   = slot_q;
    assign wr_data   = div_quo;
    assign cs_n      = cs_n_q;
    assign done      = done_q;

    // Scan state machine.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= SQ_IDLE;
            mask_q   <= '0;
            settle_q <= '0;
            ovs_q    <= '0;
            ch_q     <= '0;
            slot_q   <= '0;
            frame_q  <= '0;
            cs_n_q   <= 1'b1;
            done_q   <= 1'b0;
            go_q     <= 1'b0;
            clear_q  <= 1'b0;
            div_go_q <= 1'b0;
        end else begin
            done_q   <= 1'b0;
            go_q     <= 1'b0;
            clear_q  <= 1'b0;
            div_go_q <= 1'b0;
            case (state_q)
                SQ_IDLE: begin
                    if (start) begin
                        if (!first_found) begin
                            done_q <= 1'b1;
                        end else begin
                            mask_q   <= ch_en;
                            settle_q <= settle_cnt;
                            ovs_q    <= ovs_cnt;
                            ch_q     <= first_idx;
                            slot_q   <= '0;
                            frame_q  <= '0;
                            cs_n_q   <= 1'b0;
                            clear_q  <= 1'b1;
                            state_q  <= SQ_LAUNCH;
                        end
                    end
                end
                SQ_LAUNCH: begin
                    go_q    <= 1'b1;
                    state_q <= SQ_WAIT;
                end
                SQ_WAIT: begin
                    if (frame_vld) begin
                        if (is_last) begin
                            div_go_q <= 1'b1;
                            state_q  <= SQ_DIVIDE;
                        end else begin
                            frame_q <= frame_q + 1'b1;
                            state_q <= SQ_LAUNCH;
                        end
                    end
                end
                SQ_DIVIDE: begin
                    if (div_done) begin
                        slot_q  <= slot_q + 1'b1;
                        frame_q <= '0;
                        clear_q <= 1'b1;
                        if (next_found) begin
                            ch_q    <= next_idx;
                            state_q <= SQ_LAUNCH;
                        end else begin
                            cs_n_q  <= 1'b1;
                            done_q  <= 1'b1;
                            state_q <= SQ_IDLE;
                        end
                    end
                end
                default: state_q <= SQ_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/touch_adc_scanner.sv
// Top of the oversampling touch-ADC scan sequencer: frame engine, averager,
// sequencer and the result bank. Results are held until overwritten by a later scan.
// Assumes 2 <= NUM_CH <= 8 and HALF_DIV >= 1.
module touch_adc_scanner #(
    parameter int NUM_CH       = 8,
    parameter int CNT_W        = 4,
    parameter int SAMPLE_W     = 12,
    parameter int HALF_DIV     = 34,
    parameter bit SINGLE_ENDED = 1'b0
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         start,
    input  logic [NUM_CH-1:0]            ch_en,
    input  logic [NUM_CH*CNT_W-1:0]      settle_cnt,
    input  logic [NUM_CH*CNT_W-1:0]      ovs_cnt,
    input  logic                         miso,
    output logic                         sclk,
    output logic                         mosi,
    output logic                         cs_n,
    output logic [NUM_CH*SAMPLE_W-1:0]   result,
    output logic                         done
);

    localparam int CH_W  = $clog2(NUM_CH);
    localparam int ACC_W = SAMPLE_W + CNT_W + 4;   // headroom above the worst-case sum

    logic                frame_go;
    logic [7:0]          frame_cmd;
    logic                frame_vld;
    logic [SAMPLE_W-1:0] frame_data;
    logic                acc_clear;
    logic                acc_add;
    logic                div_go;
    logic [CNT_W-1:0]    divisor;
    logic                div_done;
    logic [SAMPLE_W-1:0] div_quo;
    logic                wr_en;
    logic [CH_W-1:0]     wr_slot;
    logic [SAMPLE_W-1:0] wr_data;
    logic [SAMPLE_W-1:0] bank_q [NUM_CH];

    tscan_spi_frame #(
        .HALF_DIV (HALF_DIV),
        .SAMPLE_W (SAMPLE_W)
    ) u_frame (
        .clk       (clk),
        .rst_n     (rst_n),
        .go        (frame_go),
        .cmd       (frame_cmd),
        .miso      (miso),
        .sclk      (sclk),
        .mosi      (mosi),
        .word_vld  (frame_vld),
        .word_data (frame_data)
    );

    tscan_averager #(
        .SAMPLE_W (SAMPLE_W),
        .CNT_W    (CNT_W),
        .ACC_W    (ACC_W)
    ) u_avg (
        .clk       (clk),
        .rst_n     (rst_n),
        .acc_clear (acc_clear),
        .acc_add   (acc_add),
        .sample    (frame_data),
        .div_go    (div_go),
        .divisor   (divisor),
        .div_done  (div_done),
        .quotient  (div_quo)
    );

    tscan_sequencer #(
        .NUM_CH       (NUM_CH),
        .CNT_W        (CNT_W),
        .SAMPLE_W     (SAMPLE_W),
        .SINGLE_ENDED (SINGLE_ENDED)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .ch_en      (ch_en),
        .settle_cnt (settle_cnt),
        .ovs_cnt    (ovs_cnt),
        .frame_vld  (frame_vld),
        .frame_go   (frame_go),
        .frame_cmd  (frame_cmd),
        .acc_clear  (acc_clear),
        .acc_add    (acc_add),
        .div_go     (div_go),
        .divisor    (divisor),
        .div_done   (div_done),
        .div_quo    (div_quo),
        .wr_en      (wr_en),
        .wr_slot    (wr_slot),
        .wr_data    (wr_data),
        .cs_n       (cs_n),
        .done       (done)
    );

    // Result bank, one register per slot.
    for (genvar k = 0; k < NUM_CH; k++) begin : g_slot
        // Capture the averaged value when this slot is addressed.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                bank_q[k] <= '0;
            end else if (wr_en && (wr_slot == CH_W'(k))) begin
                bank_q[k] <= wr_data;
            end
        end
        assign result[k*SAMPLE_W +: SAMPLE_W] = bank_q[k];
    end

endmodule

// File: rtl/tscan_checker.sv
// Protocol checker for touch_adc_scanner, attached with bind.
// Watches only the top-level pins.
module tscan_checker #(
    parameter int HALF_DIV = 34
) (
    input logic clk,
    input logic rst_n,
    input logic start,
    input logic sclk,
    input logic mosi,
    input logic cs_n,
    input logic done
);

    logic [15:0] high_run;

    // Count consecutive cycles with SCLK high.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            high_run <= '0;
        end else if (sclk) begin
            high_run <= high_run + 1'b1;
        end else begin
            high_run <= '0;
        end
    end

    // R2: clock parked low whenever the chip is deselected
    a_r2_sclk_parked: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> !sclk);

    // R2: data never moves while SCLK is high
    a_r2_mosi_steady: assert property (@(posedge clk) disable iff (!rst_n)
        sclk |-> $stable(mosi));

    // R10: every high phase lasts exactly HALF_DIV cycles
    a_r10_high_width: assert property (@(posedge clk) disable iff (!rst_n)
        (!sclk && (high_run != 16'd0)) |-> (high_run == 16'(HALF_DIV)));

    // R13: done never lasts two cycles
    a_r13_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R9: select is released when done is shown
    a_r9_cs_release: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> cs_n);

    // R9: select only drops right after an accepted start
    a_r9_cs_after_start: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cs_n) |-> $past(start));

endmodule

bind touch_adc_scanner tscan_checker #(
    .HALF_DIV (HALF_DIV)
) u_tscan_checker (
    .clk   (clk),
    .rst_n (rst_n),
    .start (start),
    .sclk  (sclk),
    .mosi  (mosi),
    .cs_n  (cs_n),
    .done  (done)
);

// File: tb/touch_adc_scanner_bench.sv
`timescale 1ns/100ps
module touch_adc_scanner_bench;

    localparam int NUM_CH   = 8;
    localparam int CNT_W    = 4;
    localparam int SAMPLE_W = 12;
    localparam int HALF_DIV = 1;
    localparam bit SE       = 1'b1;

    logic                       clk = 1'b0;
    logic                       rst_n = 1'b0;
    logic                       start = 1'b0;
    logic [NUM_CH-1:0]          ch_en = '0;
    logic [NUM_CH*CNT_W-1:0]    settle_v = '0;
    logic [NUM_CH*CNT_W-1:0]    ovs_v = '0;
    logic                       miso = 1'b0;
    logic                       sclk, mosi, cs_n, done;
    logic [NUM_CH*SAMPLE_W-1:0] result;

    int vectors = 0;
    int fails   = 0;
    int s_cnt [NUM_CH];
    int o_cnt [NUM_CH];
    int bank_m [NUM_CH];
    int seed = 0;

    // converter model state
    int         rise_cnt = 0;
    logic [7:0] cmd_sh = '0;
    logic [15:0] resp = '0;
    logic [7:0] log_cmd [512];
    int         nfr = 0;
    int         ch_frames [NUM_CH];
    int         mosi_bad = 0;
    int         sl_ch = 0;
    int         hi_run = 0;
    int         hi_bad = 0;

    always #2.5 clk = ~clk;

    touch_adc_scanner #(
        .NUM_CH(NUM_CH), .CNT_W(CNT_W), .SAMPLE_W(SAMPLE_W),
        .HALF_DIV(HALF_DIV), .SINGLE_ENDED(SE)
    ) u_touch_adc_scanner (
        .clk(clk), .rst_n(rst_n), .start(start), .ch_en(ch_en),
        .settle_cnt(settle_v), .ovs_cnt(ovs_v), .miso(miso),
        .sclk(sclk), .mosi(mosi), .cs_n(cs_n), .result(result), .done(done)
    );

    function automatic int vfun(input int ch, input int f, input int sd);
        if (sd == 999) return 4095;
        if (sd == 998) return 0;
        return (ch * 523 + f * 1871 + f * f * 13 + sd * 97) % 4096;
    endfunction

    // Converter model: frame alignment starts when select drops.
    always @(negedge cs_n) begin
        rise_cnt = 0;
        miso     = 1'b1;
    end

    always @(posedge sclk) begin
        if (rise_cnt < 8) cmd_sh = {cmd_sh[6:0], mosi};
        else if (mosi !== 1'b0) mosi_bad++;
        rise_cnt++;
        if (rise_cnt == 24) begin
            if (nfr < 512) log_cmd[nfr] = cmd_sh;
            nfr++;
            rise_cnt = 0;
        end
    end

    // Reply word: junk ones in bit 15 and bits 2:0 (R3).
    always @(negedge sclk) begin
        if (rise_cnt == 8) begin
            sl_ch = int'(cmd_sh[6:4]);
            resp  = {1'b1, 12'(vfun(sl_ch, ch_frames[sl_ch], seed)), 3'b111};
            ch_frames[sl_ch]++;
        end
        if (rise_cnt >= 8) miso = resp[23 - rise_cnt];
        else miso = 1'b1;
    end

    // R10: bench-side measurement of SCLK high width.
    always @(negedge clk) begin
        if (sclk) hi_run++;
        else begin
            if (hi_run != 0 && hi_run != HALF_DIV) hi_bad++;
            hi_run = 0;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        vectors++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic run_scan(input logic [7:0] m, input int sd, input bit poke);
        int cyc;
        int cs_bad;
        int idx;
        int slot;
        int e;
        int sum;
        logic [7:0] ecmd;
        seed     = sd;
        nfr      = 0;
        mosi_bad = 0;
        for (int c = 0; c < NUM_CH; c++) begin
            ch_frames[c] = 0;
            settle_v[c*CNT_W +: CNT_W] = CNT_W'(s_cnt[c]);
            ovs_v[c*CNT_W +: CNT_W]    = CNT_W'(o_cnt[c]);
        end
        ch_en = m;
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        cyc    = 0;
        cs_bad = 0;
        while (!done && cyc < 20000) begin
            if (cs_n) cs_bad++;
            start = (poke && cyc == 30);
            @(negedge clk);
            cyc++;
        end
        start = 1'b0;
        chk(done === 1'b1, "R13 done seen", int'(done), 1);
        if (m == 0) begin
            chk(cyc == 0, "R12 done latency", cyc, 0);
            chk(nfr == 0, "R12 no frames", nfr, 0);
        end
        chk(cs_bad == 0, "R9 select held low", cs_bad, 0);
        chk(cs_n === 1'b1, "R9 select high at done", int'(cs_n), 1);
        // expected burst contents
        idx  = 0;
        slot = 0;
        for (int c = 0; c < NUM_CH; c++) begin
            if (m[c]) begin
                e   = (o_cnt[c] == 0) ? 1 : o_cnt[c];
                sum = 0;
                for (int f = 0; f < s_cnt[c] + e; f++) begin
                    ecmd = {1'b1, 3'(c), 1'b0, SE, (f == s_cnt[c] + e - 1) ? 2'b00 : 2'b01};
                    if (idx < 512)
                        chk(log_cmd[idx] == ecmd, "R1/R6 command byte", int'(log_cmd[idx]), int'(ecmd));
                    if (f >= s_cnt[c]) sum += vfun(c, f, sd);
                    idx++;
                end
                bank_m[slot] = (sum + e - 1) / e;
                slot++;
            end
        end
        chk(nfr == idx, "R5/R8 frame count", nfr, idx);
        chk(mosi_bad == 0, "R2 MOSI low in read phase", mosi_bad, 0);
        for (int k = 0; k < NUM_CH; k++)
            chk(int'(result[k*SAMPLE_W +: SAMPLE_W]) == bank_m[k], "R3/R4/R7 result slot",
                int'(result[k*SAMPLE_W +: SAMPLE_W]), bank_m[k]);
        @(negedge clk);
        chk(done === 1'b0, "R13 single-cycle done", int'(done), 0);
        if (poke) begin
            // R11: no second scan after a start during the busy phase
            cs_bad = 0;
            for (int t = 0; t < 40; t++) begin
                if (cs_n !== 1'b1 || done !== 1'b0) cs_bad++;
                @(negedge clk);
            end
            chk(cs_bad == 0, "R11 busy start ignored", cs_bad, 0);
            chk(nfr == idx, "R11 no extra frames", nfr, idx);
        end
    endtask

    initial begin : watchdog
        repeat (195000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired (all requirements)");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin : main
        for (int k = 0; k < NUM_CH; k++) begin
            bank_m[k] = 0;
            s_cnt[k]  = 1;
            o_cnt[k]  = 1;
            ch_frames[k] = 0;
        end
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R13: reset state
        chk(cs_n === 1'b1, "R13 reset cs_n", int'(cs_n), 1);
        chk(sclk === 1'b0, "R13 reset sclk", int'(sclk), 0);
        chk(mosi === 1'b0, "R13 reset mosi", int'(mosi), 0);
        chk(done === 1'b0, "R13 reset done", int'(done), 0);
        chk(result == '0, "R13 reset results", 0, 0);

        // R12: empty mask
        run_scan(8'h00, 1, 1'b0);
        // default counts, all channels
        run_scan(8'hFF, 2, 1'b0);

        // near-exhaustive mask sweep with varied counts (R4, R5, R7)
        for (int m = 1; m < 256; m += 2) begin
            for (int c = 0; c < NUM_CH; c++) begin
                s_cnt[c] = (c + m) % 2;
                o_cnt[c] = 1 + (c + m) % 3;
            end
            run_scan(8'(m), m, 1'b0);
        end
        for (int c = 0; c < NUM_CH; c++) begin s_cnt[c] = 1; o_cnt[c] = 2; end
        run_scan(8'h80, 5, 1'b0);   // R4: single high channel lands in slot 0
        run_scan(8'h02, 6, 1'b0);

        // R7/R8: maximum counts, full-scale values, no overflow
        s_cnt[3] = 15; o_cnt[3] = 15;
        run_scan(8'h08, 999, 1'b0);
        run_scan(8'h08, 998, 1'b0);
        run_scan(8'h08, 41, 1'b0);

        // R8: oversampling 0 behaves as 1, settling 0 keeps every frame
        for (int c = 0; c < NUM_CH; c++) begin s_cnt[c] = 0; o_cnt[c] = 0; end
        run_scan(8'h21, 7, 1'b0);
        s_cnt[0] = 0; o_cnt[0] = 3; s_cnt[6] = 2; o_cnt[6] = 0;
        run_scan(8'h41, 8, 1'b0);

        // all channels, mixed counts
        for (int c = 0; c < NUM_CH; c++) begin
            s_cnt[c] = (c * 3) % 16;
            o_cnt[c] = 15 - 2 * c;
        end
        run_scan(8'hFF, 11, 1'b0);

        // R11: start pulse while busy
        for (int c = 0; c < NUM_CH; c++) begin s_cnt[c] = 1; o_cnt[c] = 1; end
        run_scan(8'h81, 12, 1'b1);

        chk(hi_bad == 0, "R10 SCLK high width", hi_bad, 0);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule